// File: doc/BRIEF.md
# Shift-Add Iterative Divider

This unit divides one unsigned fixed-point operand by another with no multiplier and no trial subtraction of the dividend. It first moves the divisor's leading one to the top of an internal register, so that the divisor becomes a mantissa in the range [1.0, 2.0). It then walks a fixed schedule of steps. At step i it tries to scale that mantissa by (1 - 2^-i). The scaling is kept only while the result still lies above 1.0. Every scaling kept on the divisor is applied to the dividend as well, so the dividend register converges on dividend / mantissa. A final shifter undoes the normalisation and saturates the result to the output width. A reciprocal is simply a division with a dividend of 1.0.

A caller pulses `start` with both operands on the same cycle and then waits for `done`. The latency is a fixed ITERS+1 cycles for every operand pair, including a zero divisor. A zero divisor raises `div_zero` and returns an all-ones quotient. Results stay on the outputs until the next `start`. A `start` that arrives while a division is still running abandons it and begins the new one.

Top module: `shiftadd_divider`

## Requirements
- R1: `divisor` and `dividend` are unsigned, DW bits wide, with FW fraction bits. They are sampled only in the cycle where `start` is high; changes on those inputs at any other time have no effect on the result.
- R2: The divisor is normalised by a left shift that places its leading one at the top bit, giving a mantissa in [1.0, 2.0). During the iterations the working divisor never falls below 1.0 and never grows. As a result, doubling a nonzero divisor halves the unsaturated quotient, with the result rounded down.
- R3: Steps run for i = 1 up to ITERS, in that order. At each step, a = x - (x >> i). If a is strictly greater than 1.0, then x becomes a and y becomes y - (y >> i); otherwise x and y both keep their values. y starts as the dividend extended with GW guard fraction bits.
- R4: With p the index of the divisor's highest set bit, the quotient is floor(y * 2^FW / 2^(p+GW)). Any value that does not fit in DW bits saturates to all ones.
- R5: When the divisor is a power of two, the quotient is exact: floor(dividend * 2^FW / divisor), saturated. A divisor of 1.0 returns the dividend unchanged.
- R6: A zero divisor sets `div_zero` high and returns an all-ones quotient. A nonzero divisor leaves `div_zero` low.
- R7: `done` and `div_zero` are low in the cycle after `start`. `done` rises exactly ITERS+1 clock edges after the edge that samples `start`, and not before.
- R8: Once `done` is high, `quotient`, `div_zero` and `done` hold their values until the next `start`.
- R9: A `start` while a division is in progress restarts the unit with the new operands. The restarted division obeys R7 counted from the new `start`, and it returns the new operands' quotient.
- R10: After reset, `done` and `div_zero` are low and `quotient` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a division; samples both operands |
| divisor | input | DW | Unsigned fixed-point divisor, FW fraction bits |
| dividend | input | DW | Unsigned fixed-point dividend, FW fraction bits |
| quotient | output | DW | Unsigned fixed-point quotient, FW fraction bits, saturating |
| done | output | 1 | Result valid; held until the next start |
| div_zero | output | 1 | Divisor was zero |

## Verification
The bench sweeps every divisor and dividend pair of a 6-bit configuration against an arithmetic model of the steps. A wrong comparison, such as one that admits a = 1.0, or a swapped shift direction would therefore change some quotient.

Powers of two and pairs of divisors that differ by a factor of two test the normalisation and the final shifter. An off-by-one shift shows up as a doubled or halved result. A missing saturation shows up as a wrapped small value where all ones is expected.

The bench counts `done` cycle by cycle, changes the operand inputs while a division runs, and restarts the unit mid-flight. These checks catch a latency off by one, an unlatched operand, and a stale result left from an abandoned division.

// File: rtl/sadiv_pkg.sv
package sadiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_WRAP = 2'd2
  } sadiv_state_e;

  // Index of the highest set bit; zero when no bit is set.
  function automatic int unsigned lead_one(input logic [31:0] v);
    int unsigned pos;
    pos = 0;
    for (int b = 0; b < 32; b++) begin
      if (v[b]) pos = b;
    end
    return pos;
  endfunction

endpackage

// File: rtl/sadiv_prenorm.sv
module sadiv_prenorm #(
  parameter int DW = 8,
  parameter int GW = 4,
  parameter int PW = 3
) (
  input  logic [DW-1:0]    divisor,
  output logic [DW+GW-1:0] mant,
  output logic [PW-1:0]    lead,
  output logic             is_zero
);
  import sadiv_pkg::*;

  logic [PW-1:0] sh_up;
  logic [DW-1:0] aligned;

  always_comb begin
    lead    = PW'(lead_one(32'(divisor)));
    sh_up   = PW'(DW - 1) - lead;
    aligned = divisor << sh_up;
    mant    = {aligned, {GW{1'b0}}};
    is_zero = (divisor == '0);
  end
endmodule

// File: rtl/sadiv_step.sv
module sadiv_step #(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int SW = 4
) (
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  input  logic [SW-1:0] sh,
  output logic [XW-1:0] x_out,
  output logic [YW-1:0] y_out,
  output logic          taken
);
  localparam logic [XW-1:0] ONE = {1'b1, {(XW-1){1'b0}}};

  logic [XW-1:0] trial;

  always_comb begin
    trial = x_in - (x_in >> sh);
    taken = (trial > ONE);
    x_out = taken ? trial : x_in;
    y_out = taken ? (y_in - (y_in >> sh)) : y_in;
  end
endmodule

// File: rtl/sadiv_post.sv
module sadiv_post #(
  parameter int DW = 8,
  parameter int FW = 4,
  parameter int GW = 4,
  parameter int PW = 3
) (
  input  logic [DW+GW-1:0] y_fin,
  input  logic [PW-1:0]    lead,
  input  logic             is_zero,
  output logic [DW-1:0]    q
);
  localparam int YW = DW + GW;
  localparam int EW = YW + FW;

  logic [EW-1:0] ext;
  logic [EW-1:0] scaled;
  logic          ovf;

  always_comb begin
    ext    = {{FW{1'b0}}, y_fin} << FW;
    scaled = ext >> (32'(lead) + 32'(GW));
    ovf    = |scaled[EW-1:DW];
    q      = (is_zero || ovf) ? {DW{1'b1}} : scaled[DW-1:0];
  end
endmodule

// File: rtl/shiftadd_divider.sv
module shiftadd_divider #(
  parameter int DW    = 8,
  parameter int FW    = 4,
  parameter int GW    = 4,
  parameter int ITERS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] divisor,
  input  logic [DW-1:0] dividend,
  output logic [DW-1:0] quotient,
  output logic          done,
  output logic          div_zero
);
  import sadiv_pkg::*;

  localparam int XW = DW + GW;
  localparam int YW = DW + GW;
  localparam int PW = (DW > 1) ? $clog2(DW) : 1;
  localparam int CW = $clog2(ITERS + 2);

  sadiv_state_e  state;
  logic [CW-1:0] cnt;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [PW-1:0] lead_q;
  logic          zero_q;
  logic [DW-1:0] q_q;
  logic          done_q;
  logic          dz_q;

  logic [XW-1:0] mant;
  logic [PW-1:0] lead_c;
  logic          zero_c;
  logic [XW-1:0] x_nx;
  logic [YW-1:0] y_nx;
  logic [DW-1:0] q_fin;

  // Named events for the checker
  logic iter_fire;
  logic step_taken;
  logic last_step;

  sadiv_prenorm #(.DW(DW), .GW(GW), .PW(PW)) u_prenorm (
    .divisor (divisor),
    .mant    (mant),
    .lead    (lead_c),
    .is_zero (zero_c)
  );

  sadiv_step #(.XW(XW), .YW(YW), .SW(CW)) u_step (
    .x_in  (x_q),
    .y_in  (y_q),
    .sh    (cnt),
    .x_out (x_nx),
    .y_out (y_nx),
    .taken (step_taken)
  );

  sadiv_post #(.DW(DW), .FW(FW), .GW(GW), .PW(PW)) u_post (
    .y_fin   (y_q),
    .lead    (lead_q),
    .is_zero (zero_q),
    .q       (q_fin)
  );

  assign iter_fire = (state == ST_ITER);
  assign last_step = iter_fire && (cnt == CW'(ITERS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      lead_q <= '0;
      zero_q <= 1'b0;
      q_q    <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (start) begin
      state  <= ST_ITER;
      cnt    <= CW'(1);
      x_q    <= mant;
      y_q    <= {dividend, {GW{1'b0}}};
      lead_q <= lead_c;
      zero_q <= zero_c;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      case (state)
        ST_ITER: begin
          x_q <= x_nx;
          y_q <= y_nx;
          if (last_step) state <= ST_WRAP;
          else           cnt   <= cnt + CW'(1);
        end
        ST_WRAP: begin
          q_q    <= q_fin;
          dz_q   <= zero_q;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign quotient = q_q;
  assign done     = done_q;
  assign div_zero = dz_q;
endmodule

// File: rtl/sadiv_chk.sv
module sadiv_chk #(
  parameter int DW    = 8,
  parameter int XW    = 12,
  parameter int ITERS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          div_zero,
  input logic [DW-1:0] quotient,
  input logic [XW-1:0] x_cur,
  input logic          iter_fire,
  input logic          step_taken,
  input logic          zero_op
);
  localparam int LW = $clog2(ITERS + 3);
  localparam logic [LW-1:0] LIM = LW'(ITERS + 2);
  localparam logic [XW-1:0] ONE = {1'b1, {(XW-1){1'b0}}};

  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat <= LIM;
    else if (start)      lat <= '0;
    else if (lat != LIM) lat <= lat + LW'(1);
  end

  // R2: working divisor stays at or above 1.0
  p_x_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iter_fire && !zero_op |-> x_cur >= ONE);

  // R2: working divisor never grows across a step
  p_x_nonrise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iter_fire && !start |=> x_cur <= $past(x_cur));

  // R3: a rejected step leaves x untouched
  p_step_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iter_fire && !step_taken && !start |=> $stable(x_cur));

  // R6: zero divisor gives full scale
  p_zero_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && div_zero |-> &quotient);

  // R7: fixed latency
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lat == LW'(ITERS + 1));

  // R7: start clears the flags
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !div_zero);

  // R8: results hold until the next start
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(quotient) && $stable(div_zero));
endmodule

bind shiftadd_divider sadiv_chk #(.DW(DW), .XW(XW), .ITERS(ITERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .div_zero   (div_zero),
  .quotient   (quotient),
  .x_cur      (x_q),
  .iter_fire  (iter_fire),
  .step_taken (step_taken),
  .zero_op    (zero_q)
);

// File: tb/shiftadd_divider_test.sv
module shiftadd_divider_test;
  localparam int DW    = 6;
  localparam int FW    = 3;
  localparam int GW    = 3;
  localparam int ITERS = 8;
  localparam int NV    = 1 << DW;
  localparam int QMAX  = NV - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] divisor = '0;
  logic [DW-1:0] dividend = '0;
  logic [DW-1:0] quotient;
  logic          done;
  logic          div_zero;

  int checks = 0;
  int errors = 0;
  int res [NV][NV];

  always #10 clk = ~clk;

  shiftadd_divider #(.DW(DW), .FW(FW), .GW(GW), .ITERS(ITERS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .divisor(divisor), .dividend(dividend),
    .quotient(quotient), .done(done), .div_zero(div_zero)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Arithmetic restatement of the step schedule using division by powers of two
  function automatic int model(input int xv, input int yv);
    int p, xm, ym, one, a, t;
    if (xv == 0) return QMAX;
    p = 0;
    for (int b = 0; b < DW; b++) if ((xv / (2 ** b)) % 2 == 1) p = b;
    xm  = xv * (2 ** (DW - 1 - p)) * (2 ** GW);
    ym  = yv * (2 ** GW);
    one = 2 ** (DW + GW - 1);
    for (int i = 1; i <= ITERS; i++) begin
      a = xm - xm / (2 ** i);
      if (a > one) begin
        xm = a;
        ym = ym - ym / (2 ** i);
      end
    end
    t = (ym * (2 ** FW)) / (2 ** (p + GW));
    return (t > QMAX) ? QMAX : t;
  endfunction

  task automatic run_op(input int xv, input int yv, output int q, output bit dz, output bit tim_ok);
    @(negedge clk);
    divisor = DW'(xv); dividend = DW'(yv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tim_ok = (done == 1'b0) && (div_zero == 1'b0);
    for (int k = 1; k <= ITERS; k++) begin
      @(negedge clk);
      if (done) tim_ok = 1'b0;
    end
    @(negedge clk);
    if (!done) tim_ok = 1'b0;
    q  = int'(quotient);
    dz = div_zero;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int q, e;
    bit dz, tok;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(div_zero == 1'b0, "R10 div_zero", int'(div_zero), 0);
    chk(quotient == '0, "R10 quotient", int'(quotient), 0);
    rst_n = 1'b1;

    // R3/R4/R6/R7 exhaustive sweep
    for (int xv = 0; xv < NV; xv++) begin
      for (int yv = 0; yv < NV; yv++) begin
        run_op(xv, yv, q, dz, tok);
        res[xv][yv] = q;
        e = model(xv, yv);
        chk(q == e, "R4 quotient", q, e);
        chk(dz == (xv == 0), "R6 div_zero", int'(dz), int'(xv == 0));
        chk(tok, "R7 latency", int'(tok), 1);
        if (xv != 0 && (xv & (xv - 1)) == 0) begin
          e = (yv * (2 ** FW)) / xv;
          if (e > QMAX) e = QMAX;
          chk(q == e, "R5 power-of-two exact", q, e);
        end
      end
    end

    // R2 doubling the divisor halves an unsaturated quotient
    for (int xv = 1; 2 * xv < NV; xv++) begin
      for (int yv = 0; yv < NV; yv++) begin
        if (res[xv][yv] != QMAX)
          chk(res[2*xv][yv] == res[xv][yv] / 2, "R2 scale invariance", res[2*xv][yv], res[xv][yv] / 2);
      end
    end

    // R1 inputs changed while busy are ignored
    @(negedge clk);
    divisor = 6'd12; dividend = 6'd21; start = 1'b1;
    @(negedge clk);
    start = 1'b0; divisor = 6'd3; dividend = 6'd60;
    repeat (ITERS + 1) @(negedge clk);
    e = model(12, 21);
    chk(int'(quotient) == e, "R1 operands latched", int'(quotient), e);

    // R8 hold after done with new input values
    divisor = 6'd0; dividend = 6'd5;
    repeat (5) @(negedge clk);
    chk(int'(quotient) == e, "R8 quotient held", int'(quotient), e);
    chk(done == 1'b1, "R8 done held", int'(done), 1);
    chk(div_zero == 1'b0, "R8 div_zero held", int'(div_zero), 0);

    // R9 restart mid-flight
    @(negedge clk);
    divisor = 6'd5; dividend = 6'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    run_op(9, 50, q, dz, tok);
    e = model(9, 50);
    chk(q == e, "R9 restart quotient", q, e);
    chk(tok, "R9 restart latency", int'(tok), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule